// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word sent on two wires per bit and tells the consumer when the whole word has arrived and when it has been fully withdrawn. Each wire pair carries both the bit's value and whether the bit is present. The pair is reduced to one presence flag per bit by ORing its two wires. The flags are then merged by a state-holding agreement element with many inputs. That element is modelled here as a register updated on every rising clock edge, so the detector can be synthesized and checked in a clocked flow.

The completion flag uses hysteresis. It goes high only once every bit is present. It goes low only once every bit has returned to the empty spacer code. While the word is partly filled or partly drained, it keeps its last value. A separate flag reports, in the same cycle, any bit whose two wires are both high, since that is not a legal code. Decoding the data value and sequencing any handshake are left to the surrounding logic.

Top module: `dualRailCompletion`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `done` is cleared, so it reads 0 after that edge.
- R2: A bit counts as present when either of its wires is high. The pair (`railHi[i]`,`railLo[i]`) = (0,1) encodes logic 0 and (1,0) encodes logic 1, and both count as present whatever the mix of values across the word.
- R3: If every bit is present at a rising edge, `done` reads 1 after that edge.
- R4: If every bit shows the empty code (0,0) at a rising edge, `done` reads 0 after that edge.
- R5: If some bits are present and others are empty at a rising edge, `done` keeps the value it had before that edge, whether that value is 0 or 1.
- R6: `illegal` is high in exactly those cycles in which at least one bit shows (1,1). It follows the inputs combinationally, with no clock delay.
- R7: A bit showing (1,1) counts as present when completion is judged, so a word made only of present and illegal bits still sets `done`.
- R8: Reset takes priority over a complete word: `rst` high at an edge clears `done` even when every bit is present.
- R9: The word width is the parameter `N` (default 8), and every bit takes part in the completion decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the held completion state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the completion state |
| railHi | input | N | Per-bit wire that is high when the bit carries logic 1 |
| railLo | input | N | Per-bit wire that is high when the bit carries logic 0 |
| done | output | 1 | Held completion flag with hysteresis |
| illegal | output | 1 | High while any bit shows both wires high |

## Verification
The only internal state is the held completion bit, so any corruption of it appears on `done` right after the edge that should have set, cleared or kept it. The most revealing stimulus is a word filled or drained one bit at a time. A detector that treats a partly filled word as full, or that drops its held value on a mixed word, changes `done` one cycle early, and that shows on the very next comparison. An error in the per-bit reduction, such as using AND where OR is needed or ignoring the top bit, shows up as a word that never completes or that completes too soon. An error in the illegal-code path appears on `illegal` in the same cycle as the offending input.

// File: rtl/drcPkg.sv
package drcPkg;

  // Word-level summary handed from the rail datapath to the hold control
  typedef struct packed {
    logic allValid;   // every bit has at least one rail high
    logic allEmpty;   // every bit has both rails low
    logic anyIllegal; // some bit has both rails high
  } railSummary_t;

endpackage

// File: rtl/drcRailReduce.sv
module drcRailReduce
  import drcPkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]  railHi,
  input  logic [N-1:0]  railLo,
  output railSummary_t  summary
);

  logic [N-1:0] bitValid;
  logic [N-1:0] bitIllegal;

  // One reduction cell per bit: presence and illegal-code detect
  for (genvar i = 0; i < N; i++) begin : gBit
    assign bitValid[i]   = railHi[i] | railLo[i];
    assign bitIllegal[i] = railHi[i] & railLo[i];
  end

  always_comb begin
    summary.allValid   = &bitValid;
    summary.allEmpty   = ~|bitValid;
    summary.anyIllegal = |bitIllegal;
  end

endmodule

// File: rtl/drcHoldCtrl.sv
module drcHoldCtrl
  import drcPkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  railSummary_t  summary,
  output logic          doneQ
);

  // Synchronous model of the multi-input agreement element
  always_ff @(posedge clk) begin
    if (rst)                   doneQ <= 1'b0;
    else if (summary.allValid) doneQ <= 1'b1;
    else if (summary.allEmpty) doneQ <= 1'b0;
  end

  // R1 / R8: reset clears the held state, even over a complete word
  assert_reset_clears_R8: assert property (@(posedge clk) rst |=> !doneQ);

  // R3: a complete word sets the flag on the next edge
  assert_full_sets_done_R3: assert property (@(posedge clk) disable iff (rst)
    summary.allValid |=> doneQ);

  // R4: a fully empty word clears the flag on the next edge
  assert_empty_clears_done_R4: assert property (@(posedge clk) disable iff (rst)
    summary.allEmpty |=> !doneQ);

  // R5: a mixed word leaves the flag unchanged
  assert_mixed_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!summary.allValid && !summary.allEmpty) |=> $stable(doneQ));

endmodule

// File: rtl/dualRailCompletion.sv
module dualRailCompletion
  import drcPkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  railHi,
  input  logic [N-1:0]  railLo,
  output logic          done,
  output logic          illegal
);

  railSummary_t summary;

  drcRailReduce #(.N(N)) reduce_i (
    .railHi  (railHi),
    .railLo  (railLo),
    .summary (summary)
  );

  drcHoldCtrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .summary (summary),
    .doneQ   (done)
  );

  assign illegal = summary.anyIllegal;

  // R7: an illegal bit is never counted as empty
  assert_illegal_not_empty_R7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !summary.allEmpty);

  // R6: the illegal flag follows the rails with no clock delay
  assert_illegal_needs_pair_R6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ((railHi & railLo) != '0));

endmodule

// File: tb/dualRailCompletion_tb.sv
module dualRailCompletion_tb_top;

  localparam int N = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst;
  logic [N-1:0] railHi, railLo;
  logic         done, illegal;

  int compared   = 0;
  int mismatched = 0;
  bit expDone    = 1'b0;
  string prevReq = "R1";

  dualRailCompletion #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .railHi(railHi), .railLo(railLo),
    .done(done), .illegal(illegal)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, written per bit from the requirements
  function automatic bit modelAllPresent(input logic [N-1:0] hi, lo);
    for (int i = 0; i < N; i++) if (!(hi[i] || lo[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit modelAllEmpty(input logic [N-1:0] hi, lo);
    for (int i = 0; i < N; i++) if (hi[i] || lo[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit modelIllegal(input logic [N-1:0] hi, lo);
    for (int i = 0; i < N; i++) if (hi[i] && lo[i]) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: check the held flag from the last edge, apply new rails,
  // check the combinational flag, then advance the model to the next edge
  task automatic step(input logic [N-1:0] hi, input logic [N-1:0] lo,
                      input string req, input bit doRst = 1'b0);
    @(negedge clk);
    check({prevReq, " done"}, done, expDone);
    railHi = hi;
    railLo = lo;
    rst    = doRst;
    #1;
    check({"R6 illegal (", req, ")"}, illegal, modelIllegal(hi, lo));
    if (doRst)                        expDone = 1'b0;
    else if (modelAllPresent(hi, lo)) expDone = 1'b1;
    else if (modelAllEmpty(hi, lo))   expDone = 1'b0;
    prevReq = req;
  endtask

  function automatic logic [N-1:0] partialMask(input int k);
    logic [N-1:0] m = '0;
    for (int i = 0; i <= k; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [N-1:0] val;
    logic [N-1:0] m;
    rst = 1'b1; railHi = '0; railLo = '0;
    // R1: reset state
    step('0, '0, "R1", 1'b1);
    step('0, '0, "R1", 1'b1);
    step('0, '0, "R4");

    // R3 / R5 / R9: fill one bit at a time, value 0xA5
    val = 8'hA5;
    for (int k = 0; k < N; k++) begin
      m = partialMask(k);
      step(val & m, ~val & m, (k == N - 1) ? "R3" : "R5");
    end
    step(val, ~val, "R3");

    // R4 / R5: drain one bit at a time
    for (int k = N - 1; k >= 0; k--) begin
      m = (k == 0) ? '0 : partialMask(k - 1);
      step(val & m, ~val & m, (k == 0) ? "R4" : "R5");
    end
    step('0, '0, "R4");

    // R2: all-zero and all-one words both count as present
    step('0, '1, "R2");
    step('0, '0, "R4");
    step('1, '0, "R2");
    step('0, '0, "R4");

    // R6 / R7: illegal code alone, then with the rest present
    step(8'h01, 8'h01, "R6");
    step(8'h01, 8'h01, "R5");
    step('0, '0, "R4");
    step(8'h81, 8'hFF, "R7");
    step(8'h80, 8'h80, "R5");

    // R8: reset over a complete word
    step(8'h3C, 8'hC3, "R3");
    step(8'h3C, 8'hC3, "R8", 1'b1);
    step(8'h01, 8'h00, "R5");
    step('0, '0, "R4");

    // R5: randomized mix of full, empty and partial words
    for (int n = 0; n < 400; n++) begin
      int mode = $urandom_range(0, 3);
      logic [N-1:0] v = N'($urandom);
      logic [N-1:0] p = N'($urandom);
      logic [N-1:0] x = N'($urandom) & N'($urandom) & N'($urandom);
      case (mode)
        0: step(v, ~v, "R3");
        1: step('0, '0, "R4");
        2: step(v & p, ~v & p, "R5");
        default: step((v & p) | x, (~v & p) | x, "R7");
      endcase
    end
    step('0, '0, "R4");
    finishRun();
  end

endmodule